// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general and status register storage for a 32-bit processor core that runs in seven operating modes. Software always addresses sixteen logical registers with a 4-bit number. The physical register that a number reaches depends on the mode currently applied at the `mode` input. Some registers are common to every mode. Others have extra copies, so that an exception handler can run without first saving the interrupted context. In total there are thirty banked or common general registers plus the program counter.

Two combinational read ports and one clocked write port serve the general registers. Register 15 is the program counter. It reads through either port and can be loaded either from its own update input or through the write port. A current status register and one saved status register for each exception mode have their own read and write ports. Each status register stores only the twelve bits that carry meaning. The core's decode logic supplies the mode code on every cycle and owns every decision about when to switch modes.

Top module: `bregs_file`

## Requirements
- R1: After reset, every general register and the program counter read as zero, the current status reads 0x000000D3 (supervisor mode with both interrupt masks set), and every saved status reads zero.
- R2: Logical registers 0 to 7 reach the same physical register in every mode. A value written in any mode reads back in all modes.
- R3: Logical registers 8 to 12 have a separate copy used only in FIQ mode. Every other mode, including system and unlisted codes, shares the base copy.
- R4: Logical registers 13 and 14 have a private copy in each of FIQ, IRQ, supervisor, abort and undefined mode. User and system mode share one base pair.
- R5: Both read ports are combinational and independent. A read of the register being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R6: A write lands in the bank chosen by the mode applied in the cycle of the write, whatever mode follows.
- R7: Logical register 15 reads the program counter on either port. When `pc_we` is high, `pc_next` is loaded. Otherwise a write-port write to register 15 loads `wr_data`. `pc_we` wins when both occur.
- R8: The current status keeps only bits 31:28 (N, Z, C, V), 7:5 (I, F, T) and 4:0 (mode field). A write stores those bits, and all other bits always read as zero.
- R9: Each of the five exception modes owns one saved status register, masked like the current status. `saved_q` and `saved_we` act on the one selected by `mode`.
- R10: In user mode, system mode and unlisted codes, `saved_q` returns the current status and a `saved_we` write changes no saved register.
- R11: Mode codes are user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other code behaves as user mode for banking and saved status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode | input | 5 | Operating mode code that selects the register bank |
| rd_a_sel | input | 4 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 4 | Logical register number for the write port |
| wr_data | input | 32 | Write port data |
| pc_we | input | 1 | Program counter update enable |
| pc_next | input | 32 | Program counter update value |
| pc_q | output | 32 | Current program counter |
| stat_we | input | 1 | Current status write enable |
| stat_wdata | input | 32 | Current status write data |
| stat_q | output | 32 | Current status value |
| saved_we | input | 1 | Saved status write enable for the current mode |
| saved_wdata | input | 32 | Saved status write data |
| saved_q | output | 32 | Saved status of the current mode |

## Verification
The assertions check on every cycle that the unstored status bits read as zero and that `saved_q` mirrors the current status outside the exception modes. They also check that register 15 on a read port equals the program counter, that the program counter loads and holds correctly, and that a write becomes readable in the next cycle under the same mode. Which modes share a physical register, and which keep a private copy, can only be shown by the bench. It fills every register in every mode with distinct values and then sweeps reads across all modes, including unlisted codes. The bench also shows that a saved-status write outside the exception modes leaves each exception mode's copy untouched.

// File: rtl/bregs_pkg.sv
package bregs_pkg;

  localparam int XLEN      = 32;
  localparam int NUM_LOW   = 8;   // registers common to all modes
  localparam int NUM_HIGH  = 5;   // registers with a FIQ-only second copy
  localparam int NUM_PRIV  = 2;   // stack and link registers, per bank
  localparam int NUM_BANKS = 6;   // base bank plus five exception banks
  localparam int NUM_EXC   = NUM_BANKS - 1;
  localparam int NUM_GPR   = NUM_LOW + 2 * NUM_HIGH + NUM_BANKS * NUM_PRIV;
  localparam int PIDX_W    = $clog2(NUM_GPR);
  localparam int PRIV_BASE = NUM_LOW + 2 * NUM_HIGH;

  localparam logic [3:0] PC_SEL = 4'd15;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BK_BASE = 3'd0,
    BK_FIQ  = 3'd1,
    BK_IRQ  = 3'd2,
    BK_SVC  = 3'd3,
    BK_ABT  = 3'd4,
    BK_UND  = 3'd5
  } bank_e;

  // Twelve stored status bits: flags and the low control byte
  typedef struct packed {
    logic [3:0] flags;  // N Z C V
    logic [7:0] ctl;    // I F T and mode field
  } stat_t;

  localparam stat_t STAT_RESET = '{flags: 4'h0, ctl: 8'hD3};

  function automatic stat_t stat_pack(input logic [XLEN-1:0] word);
    stat_t s;
    s.flags = word[XLEN-1:XLEN-4];
    s.ctl   = word[7:0];
    return s;
  endfunction

  function automatic logic [XLEN-1:0] stat_unpack(input stat_t s);
    return {s.flags, {(XLEN-12){1'b0}}, s.ctl};
  endfunction

  // R11: unlisted codes and system mode fall back to the base bank
  function automatic bank_e bank_of(input logic [4:0] m);
    case (m)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      default:  return BK_BASE;
    endcase
  endfunction

  // Logical number to physical slot; register 15 is never passed here
  function automatic logic [PIDX_W-1:0] phys_of(input bank_e b, input logic [3:0] s);
    int idx;
    if (int'(s) < NUM_LOW) begin
      idx = int'(s);
    end else if (int'(s) < NUM_LOW + NUM_HIGH) begin
      idx = (b == BK_FIQ) ? int'(s) + NUM_HIGH : int'(s);
    end else begin
      idx = PRIV_BASE + int'(b) * NUM_PRIV + (int'(s) - (NUM_LOW + NUM_HIGH));
    end
    return idx[PIDX_W-1:0];
  endfunction

endpackage

// File: rtl/bregs_map.sv
module bregs_map
  import bregs_pkg::*;
(
  input  bank_e             bank,
  input  logic [3:0]        lsel,
  output logic [PIDX_W-1:0] pidx,
  output logic              is_pc
);

  always_comb begin
    is_pc = (lsel == PC_SEL);
    pidx  = is_pc ? '0 : phys_of(bank, lsel);
  end

endmodule

// File: rtl/bregs_gpr.sv
module bregs_gpr #(
  parameter int NUM = 30,
  parameter int W   = 32,
  parameter int IW  = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx_a,
  input  logic [IW-1:0] ridx_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0]   slot_q [NUM];
  logic [NUM-1:0] slot_ld;

  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      slot_ld[i] = we && (int'(widx) == i);
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        slot_q[g] <= '0;
      end else if (slot_ld[g]) begin
        slot_q[g] <= wdata;
      end
    end
  end

  // Combinational reads see the value held before this cycle's edge
  always_comb begin
    rdata_a = slot_q[ridx_a];
    rdata_b = slot_q[ridx_b];
  end

endmodule

// File: rtl/bregs_status.sv
module bregs_status
  import bregs_pkg::*;
(
  input  logic            clk,
  input  logic            arst_n,
  input  bank_e           bank,
  input  logic            stat_we,
  input  logic [XLEN-1:0] stat_wdata,
  input  logic            saved_we,
  input  logic [XLEN-1:0] saved_wdata,
  output logic [XLEN-1:0] stat_q,
  output logic [XLEN-1:0] saved_q
);

  stat_t       cur_q;
  stat_t       cur_d;
  stat_t       sav_d;
  stat_t       sav_q [NUM_EXC];
  logic [2:0]  sav_sel;

  always_comb begin
    cur_d = stat_pack(stat_wdata);
    sav_d = stat_pack(saved_wdata);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cur_q <= STAT_RESET;
    end else if (stat_we) begin
      cur_q <= cur_d;
    end
  end

  for (genvar e = 0; e < NUM_EXC; e++) begin : g_saved
    logic ld;
    always_comb ld = saved_we && (int'(bank) == e + 1);
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        sav_q[e] <= '0;
      end else if (ld) begin
        sav_q[e] <= sav_d;
      end
    end
  end

  always_comb begin
    sav_sel = (bank == BK_BASE) ? 3'd0 : 3'(int'(bank) - 1);
    stat_q  = stat_unpack(cur_q);
    saved_q = (bank == BK_BASE) ? stat_unpack(cur_q) : stat_unpack(sav_q[sav_sel]);
  end

endmodule

// File: rtl/bregs_file.sv
module bregs_file
  import bregs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      mode,
  input  logic [3:0]      rd_a_sel,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_sel,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            pc_we,
  input  logic [XLEN-1:0] pc_next,
  output logic [XLEN-1:0] pc_q,
  input  logic            stat_we,
  input  logic [XLEN-1:0] stat_wdata,
  output logic [XLEN-1:0] stat_q,
  input  logic            saved_we,
  input  logic [XLEN-1:0] saved_wdata,
  output logic [XLEN-1:0] saved_q
);

  localparam int NPORT = 3;  // read A, read B, write

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign arst_n = rst_pipe[1];

  bank_e bank;
  always_comb bank = bank_of(mode);

  logic [3:0]        port_sel [NPORT];
  logic [PIDX_W-1:0] port_idx [NPORT];
  logic [NPORT-1:0]  port_pc;

  always_comb begin
    port_sel[0] = rd_a_sel;
    port_sel[1] = rd_b_sel;
    port_sel[2] = wr_sel;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bregs_map u_map (
      .bank  (bank),
      .lsel  (port_sel[p]),
      .pidx  (port_idx[p]),
      .is_pc (port_pc[p])
    );
  end

  logic            gpr_we;
  logic [XLEN-1:0] gpr_a;
  logic [XLEN-1:0] gpr_b;

  always_comb gpr_we = wr_en && !port_pc[2];

  bregs_gpr #(
    .NUM (NUM_GPR),
    .W   (XLEN),
    .IW  (PIDX_W)
  ) u_gpr (
    .clk     (clk),
    .arst_n  (arst_n),
    .we      (gpr_we),
    .widx    (port_idx[2]),
    .wdata   (wr_data),
    .ridx_a  (port_idx[0]),
    .ridx_b  (port_idx[1]),
    .rdata_a (gpr_a),
    .rdata_b (gpr_b)
  );

  // Program counter: dedicated update wins over the write port
  logic            pc_en;
  logic [XLEN-1:0] pc_d;

  always_comb begin
    pc_en = pc_we || (wr_en && port_pc[2]);
    pc_d  = pc_we ? pc_next : wr_data;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_comb begin
    rd_a_data = port_pc[0] ? pc_q : gpr_a;
    rd_b_data = port_pc[1] ? pc_q : gpr_b;
  end

  bregs_status u_status (
    .clk         (clk),
    .arst_n      (arst_n),
    .bank        (bank),
    .stat_we     (stat_we),
    .stat_wdata  (stat_wdata),
    .saved_we    (saved_we),
    .saved_wdata (saved_wdata),
    .stat_q      (stat_q),
    .saved_q     (saved_q)
  );

endmodule

// File: rtl/bregs_file_chk.sv
module bregs_file_chk
  import bregs_pkg::*;
(
  input logic            clk,
  input logic            arst_n,
  input logic [4:0]      mode,
  input logic [3:0]      rd_a_sel,
  input logic [XLEN-1:0] rd_a_data,
  input logic            wr_en,
  input logic [3:0]      wr_sel,
  input logic [XLEN-1:0] wr_data,
  input logic            pc_we,
  input logic [XLEN-1:0] pc_next,
  input logic [XLEN-1:0] pc_q,
  input logic            stat_we,
  input logic [XLEN-1:0] stat_wdata,
  input logic [XLEN-1:0] stat_q,
  input logic [XLEN-1:0] saved_q
);

  localparam logic [XLEN-1:0] PAD = 32'h0FFF_FF00;

  logic base_mode;
  always_comb base_mode = (mode != MODE_FIQ) && (mode != MODE_IRQ) && (mode != MODE_SVC) &&
                          (mode != MODE_ABT) && (mode != MODE_UND);

  AST_STAT_PAD_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    ((stat_q & PAD) == '0) && ((saved_q & PAD) == '0)); // R8

  AST_STAT_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
    stat_we |=> (stat_q == ($past(stat_wdata) & ~PAD))); // R8

  AST_SAVED_MIRROR: assert property (@(posedge clk) disable iff (!arst_n)
    base_mode |-> (saved_q == stat_q)); // R10

  AST_PC_ON_READ: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_a_sel == 4'd15) |-> (rd_a_data == pc_q)); // R7

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
    pc_we |=> (pc_q == $past(pc_next))); // R7

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    (!pc_we && !(wr_en && wr_sel == 4'd15)) |=> $stable(pc_q)); // R7

  AST_WRITE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_en && wr_sel != 4'd15) |=>
      (((rd_a_sel == $past(wr_sel)) && (mode == $past(mode))) ? (rd_a_data == $past(wr_data)) : 1'b1)); // R5

endmodule

bind bregs_file bregs_file_chk u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .mode       (mode),
  .rd_a_sel   (rd_a_sel),
  .rd_a_data  (rd_a_data),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .pc_we      (pc_we),
  .pc_next    (pc_next),
  .pc_q       (pc_q),
  .stat_we    (stat_we),
  .stat_wdata (stat_wdata),
  .stat_q     (stat_q),
  .saved_q    (saved_q)
);

// File: tb/bregs_file_test.sv
`timescale 1ns/1ps
module bregs_file_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode;
  logic [3:0]  rd_a_sel, rd_b_sel, wr_sel;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_next, pc_q;
  logic [31:0] stat_wdata, stat_q, saved_wdata, saved_q;
  logic        wr_en, pc_we, stat_we, saved_we;

  always #4 clk = ~clk;  // 125 MHz

  bregs_file uut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc_we(pc_we), .pc_next(pc_next), .pc_q(pc_q),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
    .saved_we(saved_we), .saved_wdata(saved_wdata), .saved_q(saved_q)
  );

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // Reference model: one 15-register view per bank; a write updates every view sharing it
  logic [31:0] view  [6][15];
  logic [31:0] m_pc, m_stat;
  logic [31:0] m_saved [6];
  localparam logic [31:0] KEEP = 32'hF000_00FF;

  logic [4:0] mlist [8];
  initial begin
    mlist[0] = 5'b10000; mlist[1] = 5'b10001; mlist[2] = 5'b10010; mlist[3] = 5'b10011;
    mlist[4] = 5'b10111; mlist[5] = 5'b11011; mlist[6] = 5'b11111; mlist[7] = 5'b00101;
  end

  function automatic int bk(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit shares(input int a, input int b, input int r);
    if (r < 8)  return 1'b1;
    if (r < 13) return (a == 1) == (b == 1);
    return a == b;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] s);
    if (s == 4'd15) return m_pc;
    return view[bk(mode)][s];
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 6; k++) begin
      for (int r = 0; r < 15; r++) view[k][r] = '0;
      m_saved[k] = '0;
    end
    m_pc   = '0;
    m_stat = 32'h0000_00D3;
  endtask

  task automatic model_edge();
    int b;
    b = bk(mode);
    if (wr_en && wr_sel != 4'd15)
      for (int k = 0; k < 6; k++)
        if (shares(b, k, int'(wr_sel))) view[k][wr_sel] = wr_data;
    if (pc_we) m_pc = pc_next;
    else if (wr_en && wr_sel == 4'd15) m_pc = wr_data;
    if (stat_we) m_stat = stat_wdata & KEEP;
    if (saved_we && b != 0) m_saved[b] = saved_wdata & KEEP;
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s mode=%b: actual %h expected %h", tag, what, mode, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    #1;
    check(tag, "rd_a", rd_a_data, exp_rd(rd_a_sel));
    check(tag, "rd_b", rd_b_data, exp_rd(rd_b_sel));
    check(tag, "pc",   pc_q, m_pc);
    check(tag, "stat", stat_q, m_stat);
    check(tag, "saved", saved_q, (bk(mode) == 0) ? m_stat : m_saved[bk(mode)]);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; pc_we = 0; stat_we = 0; saved_we = 0;
  endtask

  task automatic sweep(input string tag_override);
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 15; r++) begin
        mode = mlist[m]; rd_a_sel = 4'(r); rd_b_sel = 4'(14 - r);
        if (tag_override != "")  cyc(tag_override);
        else if (m == 7)         cyc("R11");
        else if (r < 8)          cyc("R2");
        else if (r < 13)         cyc("R3");
        else                     cyc("R4");
      end
  endtask

  initial begin
    rst_n = 0; mode = 5'b10011; rd_a_sel = 0; rd_b_sel = 0; wr_sel = 0;
    wr_data = 0; pc_next = 0; stat_wdata = 0; saved_wdata = 0;
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset contents in every mode
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 16; r++) begin
        mode = mlist[m]; rd_a_sel = 4'(r); rd_b_sel = 4'(15 - r);
        cyc("R1");
      end

    // R6: fill every register of every mode with distinct values
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 15; r++) begin
        mode = mlist[m]; wr_en = 1; wr_sel = 4'(r);
        wr_data = 32'hA500_0000 | (32'(m) << 8) | 32'(r);
        rd_a_sel = 4'(r); rd_b_sel = 4'd15;
        cyc("R6");
      end
    idle();
    sweep("");

    // R5: same-cycle read of the register being written returns old value
    mode = 5'b10010; wr_en = 1; wr_sel = 4'd13; wr_data = 32'hDEAD_0013;
    rd_a_sel = 4'd13; rd_b_sel = 4'd13;
    cyc("R5");
    idle(); cyc("R5");
    // R6: a write followed by a mode change stays in the writing mode's bank
    mode = 5'b10001; wr_en = 1; wr_sel = 4'd10; wr_data = 32'hF1F1_000A; rd_a_sel = 4'd10; rd_b_sel = 4'd3;
    cyc("R6");
    idle(); mode = 5'b10000; cyc("R6");
    mode = 5'b10001; cyc("R6");
    mode = 5'b10011; wr_en = 1; wr_sel = 4'd3; wr_data = 32'h0000_3333; rd_a_sel = 4'd3;
    cyc("R5");
    idle(); mode = 5'b11111; cyc("R2");

    // R7: program counter paths
    rd_a_sel = 4'd15; rd_b_sel = 4'd15;
    pc_we = 1; pc_next = 32'h0000_1000; cyc("R7");
    idle(); wr_en = 1; wr_sel = 4'd15; wr_data = 32'h0000_2004; cyc("R7");
    wr_en = 1; wr_sel = 4'd15; wr_data = 32'hBAD0_0000; pc_we = 1; pc_next = 32'h0000_3008; cyc("R7");
    idle(); cyc("R7");

    // R8: only the twelve kept status bits survive
    stat_we = 1; stat_wdata = 32'hFFFF_FFFF; cyc("R8");
    stat_wdata = 32'h1234_5678; cyc("R8");
    stat_wdata = 32'hA000_0011; cyc("R8");
    idle(); cyc("R8");

    // R9: one saved status per exception mode
    for (int m = 1; m < 6; m++) begin
      mode = mlist[m]; saved_we = 1; saved_wdata = 32'hC0C0_C0C0 ^ (32'(m) * 32'h1100_0011);
      cyc("R9");
    end
    idle();
    for (int m = 0; m < 8; m++) begin mode = mlist[m]; cyc("R9"); end

    // R10: saved writes outside exception modes change nothing
    mode = 5'b10000; saved_we = 1; saved_wdata = 32'hFFFF_FFFF; cyc("R10");
    mode = 5'b11111; saved_wdata = 32'h7000_0055; cyc("R10");
    mode = 5'b01010; saved_wdata = 32'h3000_0022; cyc("R11");
    idle();
    for (int m = 0; m < 8; m++) begin mode = mlist[m]; cyc("R10"); end

    sweep("R4");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule